// File: doc/BRIEF.md
# Stereo Broadcast Multiplex Generator

This block turns a stream of 16-bit left and right audio pairs into the composite baseband that drives a stereo FM modulator. Each composite sample has three parts. The first is the mono sum of the two channels. The second is the channel difference, multiplied onto a 38 kHz subcarrier as double sideband with the carrier suppressed. The third is a 19 kHz pilot tone at roughly 9% of full scale. The pilot lets a receiver rebuild the subcarrier.

Composite samples come out at three times the audio rate. A new audio pair arrives with a one-cycle strobe. A separate sub-sample tick runs at three times the audio rate, for example 132.3 kHz for 44.1 kHz audio. The most recent pair is reused for every tick until the next strobe. Both carriers come from 16-bit phase accumulators that advance on every tick and start at zero. The subcarrier step is exactly twice the pilot step, so the subcarrier crosses zero upward at every pilot zero crossing. Both sines are read from one quarter-wave table.

Each composite sample is registered once and appears on the port at the next tick. This gives a fixed one-tick delay. Overflow when the sum or difference is formed saturates the value and raises a sticky flag. The flag stays set until it is cleared explicitly.

Top module: `stereo_mpx_gen`

## Requirements
- R1: While rst_n is low, and until the first tick after it is released, mpx_out is 0 and ovf_flag is 0. Both carrier phases start at 0.
- R2: The pilot phase is a 16-bit accumulator. It starts at 0 and adds 0x24C4, modulo 2^16, on every cycle with tick high.
- R3: The subcarrier phase adds 0x4988, modulo 2^16, on every tick. At all times it equals twice the pilot phase, modulo 2^16.
- R4: The sine of a phase p uses a = p[13:8] and quadrant q = p[15:14], with table entry T(k) = round(32767·sin(π/2·(k+0.5)/64)). The sine is T(a) for q=0, T(63-a) for q=1, -T(a) for q=2 and -T(63-a) for q=3.
- R5: On a cycle with audio_valid high, the block stores S = L+R and D = L-R, each saturated to the signed 16-bit range [-32768, 32767]. The stored pair is used for every tick until the next strobe.
- R6: ovf_flag goes high the cycle after a strobe whose S or D saturated. It stays high until a cycle with ovf_clear high, after which it reads 0. If the same cycle also has a saturating strobe, the flag stays high.
- R7: The composite value is C = S·2^15 + D·sin38 + sin19·0x0B85, computed without rounding and saturated to the signed 32-bit range.
- R8: On each tick, mpx_out takes the composite that was computed at the previous tick. That composite used the phases and the S/D pair held just before that tick. Between ticks, mpx_out holds its value.
- R9: When audio_valid and tick are high in the same cycle, that tick's composite uses the previously stored pair. The new pair applies from the next tick on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| audio_valid | input | 1 | Strobe: new left/right pair present |
| left_in | input | 16 | Left audio sample, signed Q1.15 |
| right_in | input | 16 | Right audio sample, signed Q1.15 |
| tick | input | 1 | Sub-sample tick at three times the audio rate |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| mpx_out | output | 32 | Composite sample, signed Q2.30 |
| ovf_flag | output | 1 | Sticky sum/difference overflow indicator |

## Verification
The first pattern is silence (both channels zero), which leaves only the pilot. It tests the pilot phase stepping and every sine quadrant without the other terms getting in the way. Equal channels cancel the subcarrier term and so test the sum path alone. Opposite channels cancel the sum and show whether the subcarrier phase is really twice the pilot phase. A pseudo-random sweep mixes all three terms over many carrier phases. Full-scale pairs drive the input saturation, the sticky flag with its clear and set-versus-clear priority, and 32-bit output clipping. A strobe coinciding with a tick tells apart the old-pair and new-pair orderings.

// File: rtl/stereo_mpx_pkg.sv
package stereo_mpx_pkg;
  localparam int PHASE_W    = 16;
  localparam int AUDIO_W    = 16;
  localparam int OUT_W      = 32;
  localparam int QTR_ABITS  = 6;
  localparam logic [PHASE_W-1:0] PILOT_INC = 16'h24C4;
  localparam logic [PHASE_W-1:0] SUB_INC   = 16'h4988;
  localparam int PILOT_GAIN = 32'h0B85;
  localparam int ACC_W      = OUT_W + 2;

  typedef logic signed [AUDIO_W-1:0] sample_t;
  typedef logic [PHASE_W-1:0]        phase_t;
endpackage

// File: rtl/mpx_nco.sv
module mpx_nco #(
  parameter int                 W   = 16,
  parameter logic [W-1:0]       INC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] phase
);
  logic [W-1:0] phase_q, phase_nxt;

  always_comb begin
    phase_nxt = phase_q;
    if (adv) phase_nxt = phase_q + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_nxt;
  end

  assign phase = phase_q;
endmodule

// File: rtl/mpx_sine_lut.sv
module mpx_sine_lut #(
  parameter int ABITS = 6,
  parameter int OUT_W = 16
) (
  input  logic [ABITS+1:0]         phase_top,
  output logic signed [OUT_W-1:0]  sine
);
  localparam int QN = 1 << ABITS;
  localparam real HALF_PI = 1.5707963267948966;
  localparam real AMP = real'((1 << (OUT_W-1)) - 1);

  logic [OUT_W-1:0] qtab [QN];

  for (genvar i = 0; i < QN; i++) begin : g_tab
    localparam real ANG = HALF_PI * (real'(i) + 0.5) / real'(QN);
    localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
    assign qtab[i] = VAL[OUT_W-1:0];
  end

  logic [1:0]       quad;
  logic [ABITS-1:0] idx, addr;
  logic [OUT_W-1:0] mag;

  always_comb begin
    quad = phase_top[ABITS+1:ABITS];
    idx  = phase_top[ABITS-1:0];
    addr = quad[0] ? ~idx : idx;
    mag  = qtab[addr];
    sine = quad[1] ? -$signed(mag) : $signed(mag);
  end
endmodule

// File: rtl/mpx_audio_front.sv
module mpx_audio_front
  import stereo_mpx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  sample_t left,
  input  sample_t right,
  input  logic    clr,
  output sample_t sum_q,
  output sample_t diff_q,
  output logic    ovf_q
);
  localparam sample_t POS_MAX = sample_t'({1'b0, {(AUDIO_W-1){1'b1}}});
  localparam sample_t NEG_MIN = sample_t'({1'b1, {(AUDIO_W-1){1'b0}}});

  logic signed [AUDIO_W:0] sum_w, diff_w;
  logic    sum_ovf, diff_ovf;
  sample_t sum_sat, diff_sat, sum_nxt, diff_nxt;
  logic    ovf_nxt;

  always_comb begin
    sum_w    = {left[AUDIO_W-1], left} + {right[AUDIO_W-1], right};
    diff_w   = {left[AUDIO_W-1], left} - {right[AUDIO_W-1], right};
    sum_ovf  = sum_w[AUDIO_W]  != sum_w[AUDIO_W-1];
    diff_ovf = diff_w[AUDIO_W] != diff_w[AUDIO_W-1];
    sum_sat  = sum_ovf  ? (sum_w[AUDIO_W]  ? NEG_MIN : POS_MAX) : sum_w[AUDIO_W-1:0];
    diff_sat = diff_ovf ? (diff_w[AUDIO_W] ? NEG_MIN : POS_MAX) : diff_w[AUDIO_W-1:0];
    sum_nxt  = load ? sum_sat  : sum_q;
    diff_nxt = load ? diff_sat : diff_q;
    if (load && (sum_ovf || diff_ovf)) ovf_nxt = 1'b1;
    else if (clr)                      ovf_nxt = 1'b0;
    else                               ovf_nxt = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      diff_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      sum_q  <= sum_nxt;
      diff_q <= diff_nxt;
      ovf_q  <= ovf_nxt;
    end
  end
endmodule

// File: rtl/stereo_mpx_gen.sv
module stereo_mpx_gen
  import stereo_mpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              audio_valid,
  input  logic [AUDIO_W-1:0] left_in,
  input  logic [AUDIO_W-1:0] right_in,
  input  logic              tick,
  input  logic              ovf_clear,
  output logic [OUT_W-1:0]  mpx_out,
  output logic              ovf_flag
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  phase_t  ph_pilot, ph_sub;
  sample_t s19, s38, sum_q, diff_q;

  mpx_nco #(.W(PHASE_W), .INC(PILOT_INC)) u_nco_pilot (
    .clk(clk), .rst_n(rst_int_n), .adv(tick), .phase(ph_pilot));
  mpx_nco #(.W(PHASE_W), .INC(SUB_INC)) u_nco_sub (
    .clk(clk), .rst_n(rst_int_n), .adv(tick), .phase(ph_sub));

  mpx_sine_lut #(.ABITS(QTR_ABITS), .OUT_W(AUDIO_W)) u_sin_pilot (
    .phase_top(ph_pilot[PHASE_W-1 -: QTR_ABITS+2]), .sine(s19));
  mpx_sine_lut #(.ABITS(QTR_ABITS), .OUT_W(AUDIO_W)) u_sin_sub (
    .phase_top(ph_sub[PHASE_W-1 -: QTR_ABITS+2]), .sine(s38));

  mpx_audio_front u_front (
    .clk(clk), .rst_n(rst_int_n), .load(audio_valid),
    .left(sample_t'(left_in)), .right(sample_t'(right_in)), .clr(ovf_clear),
    .sum_q(sum_q), .diff_q(diff_q), .ovf_q(ovf_flag));

  localparam logic signed [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [OUT_W-1:0] sub_prod, pil_prod, comp_sat;
  logic signed [ACC_W-1:0] acc_w;
  logic [OUT_W-1:0]        pend_q, pend_nxt, out_q, out_nxt;

  always_comb begin
    sub_prod = diff_q * s38;
    pil_prod = s19 * $signed(PILOT_GAIN);
    acc_w    = (ACC_W'(sum_q) <<< (AUDIO_W-1)) + ACC_W'(sub_prod) + ACC_W'(pil_prod);
    if (acc_w > ACC_W'(OUT_MAX))      comp_sat = OUT_MAX;
    else if (acc_w < ACC_W'(OUT_MIN)) comp_sat = OUT_MIN;
    else                              comp_sat = acc_w[OUT_W-1:0];
    pend_nxt = tick ? comp_sat : pend_q;
    out_nxt  = tick ? pend_q   : out_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= '0;
      out_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      out_q  <= out_nxt;
    end
  end

  assign mpx_out = out_q;
endmodule

module stereo_mpx_gen_chk
  import stereo_mpx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             audio_valid,
  input logic             ovf_clear,
  input logic             ovf_flag,
  input logic [OUT_W-1:0] mpx_out,
  input phase_t           ph_pilot,
  input phase_t           ph_sub
);
  AST_PHASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ph_sub == {ph_pilot[PHASE_W-2:0], 1'b0});                              // R3
  AST_PILOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ph_pilot == phase_t'($past(ph_pilot) + PILOT_INC));           // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mpx_out));                                           // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);                                // R6
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !audio_valid) |=> !ovf_flag);                            // R6
  AST_RESET_OUT: assert property (@(posedge clk)
    !rst_n |-> (mpx_out == '0 && !ovf_flag));                              // R1
endmodule

bind stereo_mpx_gen stereo_mpx_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .audio_valid(audio_valid),
  .ovf_clear(ovf_clear), .ovf_flag(ovf_flag), .mpx_out(mpx_out),
  .ph_pilot(ph_pilot), .ph_sub(ph_sub));

// File: tb/stereo_mpx_gen_tb.sv
module stereo_mpx_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        audio_valid = 1'b0;
  logic [15:0] left_in = '0, right_in = '0;
  logic        tick = 1'b0;
  logic        ovf_clear = 1'b0;
  logic [31:0] mpx_out;
  logic        ovf_flag;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  longint m_sum = 0, m_diff = 0, m_pend = 0, m_out = 0;
  int     m_p19 = 0, m_p38 = 0;
  bit     m_ovf = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_mpx_gen u_dut (
    .clk(clk), .rst_n(rst_n), .audio_valid(audio_valid), .left_in(left_in),
    .right_in(right_in), .tick(tick), .ovf_clear(ovf_clear),
    .mpx_out(mpx_out), .ovf_flag(ovf_flag));

  // R4 reference sine
  function automatic longint sine_ref(int ph);
    int q = (ph >> 14) & 3;
    int a = (ph >> 8) & 63;
    longint v;
    if (q & 1) a = 63 - a;
    v = longint'($rtoi(32767.0 * $sin(1.5707963267948966 * (real'(a) + 0.5) / 64.0) + 0.5));
    return (q & 2) ? -v : v;
  endfunction

  // R7 reference composite
  function automatic longint comp_ref();
    longint c = m_sum * 32768 + m_diff * sine_ref(m_p38) + sine_ref(m_p19) * 2949;
    if (c > 64'sd2147483647)  c = 64'sd2147483647;
    if (c < -64'sd2147483648) c = -64'sd2147483648;
    return c;
  endfunction

  function automatic longint sat16(longint v, inout bit o);
    if (v > 32767)  begin o = 1'b1; return 32767;  end
    if (v < -32768) begin o = 1'b1; return -32768; end
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_tick();
    m_out  = m_pend;
    m_pend = comp_ref();
    m_p19  = (m_p19 + 'h24C4) & 'hFFFF;       // R2
    m_p38  = (m_p38 + 'h4988) & 'hFFFF;       // R3
  endfunction

  function automatic void model_load(int l, int r);
    bit o = 1'b0;
    m_sum  = sat16(longint'(l) + r, o);       // R5
    m_diff = sat16(longint'(l) - r, o);
    if (o) m_ovf = 1'b1;
  endfunction

  task automatic do_tick(string req);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    model_tick();
    check(req, longint'($signed(mpx_out)), m_out);
    @(negedge clk);
    check("R8 hold", longint'($signed(mpx_out)), m_out);
  endtask

  task automatic do_load(int l, int r, bit clr);
    @(negedge clk);
    audio_valid = 1'b1; ovf_clear = clr;
    left_in = 16'(l); right_in = 16'(r);
    @(negedge clk);
    audio_valid = 1'b0; ovf_clear = 1'b0;
    if (clr) m_ovf = 1'b0;
    model_load(l, r);
    check("R6 flag", longint'(ovf_flag), longint'(m_ovf));
  endtask

  task automatic group(int l, int r, string req);
    do_load(l, r, 1'b0);
    for (int k = 0; k < 3; k++) do_tick(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out", longint'(mpx_out), 0);
    check("R1 flag", longint'(ovf_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out after release", longint'(mpx_out), 0);
    // silence: pilot only, all quadrants over many ticks (R2, R4)
    for (int g = 0; g < 10; g++) group(0, 0, "R2/R4 pilot");
    // equal channels: no subcarrier term (R5, R7)
    for (int g = 0; g < 4; g++) group(1000 * (g + 1), 1000 * (g + 1), "R5 sum");
    // opposite channels: subcarrier term only (R3)
    for (int g = 0; g < 6; g++) group(3000 * (g + 1), -3000 * (g + 1), "R3 sub");
    // pseudo-random sweep (R7, R8)
    for (int g = 0; g < 20; g++) begin
      int l, r;
      lcg = lcg * 1664525 + 1013904223; l = int'($signed(lcg[31:16]));
      lcg = lcg * 1664525 + 1013904223; r = int'($signed(lcg[31:16]));
      group(l, r, "R7 mix");
    end
    // saturation and sticky flag (R6, R5, R7 clipping)
    for (int g = 0; g < 6; g++) group(32767, 0, "R7 clip");
    group(32767, 32767, "R5 sat");
    group(0, 0, "R6 sticky");
    check("R6 stays", longint'(ovf_flag), 1);
    @(negedge clk) ovf_clear = 1'b1;
    @(negedge clk) ovf_clear = 1'b0;
    m_ovf = 1'b0;
    check("R6 cleared", longint'(ovf_flag), 0);
    do_load(-32768, -32768, 1'b1);            // set wins over clear
    check("R6 set wins", longint'(ovf_flag), 1);
    for (int k = 0; k < 3; k++) do_tick("R5 hold");
    // R9: strobe together with tick
    @(negedge clk);
    audio_valid = 1'b1; tick = 1'b1; left_in = 16'd5000; right_in = -16'sd7000;
    @(negedge clk);
    audio_valid = 1'b0; tick = 1'b0;
    model_tick();
    model_load(5000, -7000);
    check("R9 coincident", longint'($signed(mpx_out)), m_out);
    for (int k = 0; k < 3; k++) do_tick("R9 new pair");
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule